// File: doc/BRIEF.md
# Nibble Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small 4-bit controller core. The core supplies the accumulator value, the Y index value, a memory nibble, an immediate nibble, the current carry flag and an operation code. The block returns the new accumulator nibble and new values for three status flags: ST (status), Z (zero) and C (carry). Each of these four outputs has its own write-enable, so any flag that an operation does not touch keeps its old value in the core's register file.

All arithmetic is done one bit wider than the nibble. The extra bit becomes the carry, and ST is its inverse. Logic operations, negate and the compares instead set ST from a zero test. Each operation writes only its own subset of the flags. The decimal adjust that follows a subtraction adds 10 rather than subtracting 6.

The outputs are registered. Results and enables appear one clock edge after the operands and the operation code are presented. The core is expected to present one operation per cycle.

Top module: `alu4_core`

## Requirements
- R1: Outputs are registered, and each result is valid after the first rising clock edge that follows its inputs. While rst_n is low, every output and every write-enable is 0.
- R2: Operation code 0 (add with carry) forms the 5-bit sum M + A + C. It writes A with the low nibble and C with bit 4. ST is the inverse of bit 4, and Z is 1 when the low nibble is 0. All four write-enables are 1.
- R3: Operation code 1 (subtract with carry) forms M − A − C modulo 32 and applies the same result and flag rule as R2.
- R4: Operation code 2 (add immediate) forms imm + A and applies the same result and flag rule as R2. The carry input is not used.
- R5: Operation codes 3 and 4 (decimal adjust after add and after subtract) add 6 (code 3) or 10 (code 4) to A when C is 1 or A is greater than 9. Otherwise A passes through unchanged. A, C and ST are written from the 5-bit value as in R2. Z is not written.
- R6: Operation code 5 (rotate left) produces {A[2:0], C}. The new C is the old A[3], and ST is its inverse. Z is the zero test of the result. A, Z, C and ST are all written.
- R7: Operation code 6 (rotate right) produces {C, A[3:1]}. The new C is the old A[0], and ST is its inverse. Z is the zero test of the result. A, Z, C and ST are all written.
- R8: Operation code 7 (negate) writes A with (−A) mod 16. It writes ST as 1 when that result is nonzero and 0 when it is zero. Z and C are not written.
- R9: Operation codes 8 (AND) and 9 (OR) combine A with M. They write A and Z, and set ST to the inverse of Z. C is not written.
- R10: Operation code 10 (XOR) combines A with M. It writes A, sets ST to 1 when the result is nonzero, and sets Z to the inverse of ST. C is not written.
- R11: Operation codes 11, 12 and 13 compare M − A, imm − A and imm − Y respectively, modulo 32. C is bit 4 of the difference. ST is 1 when the low nibble is nonzero, and Z is the inverse of ST. Z, C and ST are written, and A is not written.
- R12: Operation codes 14 and 15 assert no write-enable.
- R13: Whenever A and Z are both written, Z is 1 exactly when the stored nibble is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 4 | Operation code |
| a_i | input | 4 | Accumulator operand |
| y_i | input | 4 | Y index operand |
| m_i | input | 4 | Memory nibble operand |
| imm_i | input | 4 | Immediate operand |
| c_i | input | 1 | Current carry flag |
| res_o | output | 4 | New accumulator value |
| a_we_o | output | 1 | Write-enable for the accumulator |
| z_o | output | 1 | New zero flag |
| z_we_o | output | 1 | Write-enable for the zero flag |
| c_o | output | 1 | New carry flag |
| c_we_o | output | 1 | Write-enable for the carry flag |
| st_o | output | 1 | New status flag |
| st_we_o | output | 1 | Write-enable for the status flag |

## Verification
Every result, flag and write-enable of this block is due exactly one rising edge after its operands and operation code are applied, because one register sits between them and the ports. The bench therefore applies each operand set on a falling edge and compares all eleven output bits on the next falling edge, half a period after the registering edge. The sweep covers every operation code, accumulator value, memory nibble and carry value. The immediate and Y operands are derived from the memory nibble so that the compare and add-immediate paths see varied values. The reset check samples the outputs while reset is still held and an operation code is applied.

// File: rtl/alu4_pkg.sv
`timescale 1ns/1ps
package alu4_pkg;

    localparam int unsigned NIB_W     = 4;
    localparam int unsigned DEC_LIMIT = 9;
    localparam int unsigned ADJ_ADD   = 6;
    localparam int unsigned ADJ_SUB   = 10;

    typedef enum logic [3:0] {
        OP_ADC  = 4'd0,
        OP_SBC  = 4'd1,
        OP_ADI  = 4'd2,
        OP_DAA  = 4'd3,
        OP_DAS  = 4'd4,
        OP_ROL  = 4'd5,
        OP_ROR  = 4'd6,
        OP_NEG  = 4'd7,
        OP_AND  = 4'd8,
        OP_OR   = 4'd9,
        OP_XOR  = 4'd10,
        OP_CMPM = 4'd11,
        OP_CMPI = 4'd12,
        OP_CMPY = 4'd13,
        OP_RSV0 = 4'd14,
        OP_RSV1 = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic [NIB_W-1:0] res;
        logic             a_we;
        logic             z;
        logic             z_we;
        logic             c;
        logic             c_we;
        logic             st;
        logic             st_we;
    } alu_out_t;

endpackage

// File: rtl/alu4_arith.sv
`timescale 1ns/1ps
module alu4_arith
    import alu4_pkg::*;
(
    input  alu_op_e          op_i,
    input  logic [NIB_W-1:0] a_i,
    input  logic [NIB_W-1:0] y_i,
    input  logic [NIB_W-1:0] m_i,
    input  logic [NIB_W-1:0] imm_i,
    input  logic             c_i,
    output alu_out_t         out_o
);
    localparam int unsigned XW = NIB_W + 1;

    logic [XW-1:0]    lhs_d, rhs_d, raw_d;
    logic             sub_d;
    logic             cin_d;
    logic             need_adj_d;
    logic [NIB_W-1:0] low_d;

    always_comb begin
        lhs_d      = '0;
        rhs_d      = '0;
        sub_d      = 1'b0;
        cin_d      = 1'b0;
        need_adj_d = c_i || (a_i > NIB_W'(DEC_LIMIT));
        unique case (op_i)
            OP_ADC:  begin lhs_d = XW'(m_i);   rhs_d = XW'(a_i); cin_d = c_i; end
            OP_SBC:  begin lhs_d = XW'(m_i);   rhs_d = XW'(a_i); cin_d = c_i; sub_d = 1'b1; end
            OP_ADI:  begin lhs_d = XW'(imm_i); rhs_d = XW'(a_i); end
            OP_DAA:  begin lhs_d = XW'(a_i);   rhs_d = need_adj_d ? XW'(ADJ_ADD) : '0; end
            OP_DAS:  begin lhs_d = XW'(a_i);   rhs_d = need_adj_d ? XW'(ADJ_SUB) : '0; end
            OP_NEG:  begin lhs_d = '0;         rhs_d = XW'(a_i); sub_d = 1'b1; end
            OP_CMPM: begin lhs_d = XW'(m_i);   rhs_d = XW'(a_i); sub_d = 1'b1; end
            OP_CMPI: begin lhs_d = XW'(imm_i); rhs_d = XW'(a_i); sub_d = 1'b1; end
            OP_CMPY: begin lhs_d = XW'(imm_i); rhs_d = XW'(y_i); sub_d = 1'b1; end
            default: ;
        endcase
        raw_d = sub_d ? (lhs_d - rhs_d - XW'(cin_d))
                      : (lhs_d + rhs_d + XW'(cin_d));
        low_d = raw_d[NIB_W-1:0];
    end

    always_comb begin
        out_o = '0;
        unique case (op_i)
            OP_ADC, OP_SBC, OP_ADI: begin
                out_o.res   = low_d;
                out_o.a_we  = 1'b1;
                out_o.z     = (low_d == '0);
                out_o.z_we  = 1'b1;
                out_o.c     = raw_d[NIB_W];
                out_o.c_we  = 1'b1;
                out_o.st    = ~raw_d[NIB_W];
                out_o.st_we = 1'b1;
            end
            OP_DAA, OP_DAS: begin
                out_o.res   = low_d;
                out_o.a_we  = 1'b1;
                out_o.c     = raw_d[NIB_W];
                out_o.c_we  = 1'b1;
                out_o.st    = ~raw_d[NIB_W];
                out_o.st_we = 1'b1;
            end
            OP_NEG: begin
                out_o.res   = low_d;
                out_o.a_we  = 1'b1;
                out_o.st    = (low_d != '0);
                out_o.st_we = 1'b1;
            end
            OP_CMPM, OP_CMPI, OP_CMPY: begin
                out_o.st    = (low_d != '0);
                out_o.st_we = 1'b1;
                out_o.z     = (low_d == '0);
                out_o.z_we  = 1'b1;
                out_o.c     = raw_d[NIB_W];
                out_o.c_we  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/alu4_logic.sv
`timescale 1ns/1ps
module alu4_logic
    import alu4_pkg::*;
(
    input  alu_op_e          op_i,
    input  logic [NIB_W-1:0] a_i,
    input  logic [NIB_W-1:0] m_i,
    input  logic             c_i,
    output alu_out_t         out_o
);
    logic [NIB_W-1:0] val_d;
    logic             zero_d;

    always_comb begin
        unique case (op_i)
            OP_ROL:  val_d = {a_i[NIB_W-2:0], c_i};
            OP_ROR:  val_d = {c_i, a_i[NIB_W-1:1]};
            OP_AND:  val_d = a_i & m_i;
            OP_OR:   val_d = a_i | m_i;
            OP_XOR:  val_d = a_i ^ m_i;
            default: val_d = '0;
        endcase
        zero_d = (val_d == '0);
    end

    always_comb begin
        out_o = '0;
        unique case (op_i)
            OP_ROL, OP_ROR: begin
                out_o.res   = val_d;
                out_o.a_we  = 1'b1;
                out_o.z     = zero_d;
                out_o.z_we  = 1'b1;
                out_o.c     = (op_i == OP_ROL) ? a_i[NIB_W-1] : a_i[0];
                out_o.c_we  = 1'b1;
                out_o.st    = (op_i == OP_ROL) ? ~a_i[NIB_W-1] : ~a_i[0];
                out_o.st_we = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR: begin
                out_o.res   = val_d;
                out_o.a_we  = 1'b1;
                out_o.z     = zero_d;
                out_o.z_we  = 1'b1;
                out_o.st    = ~zero_d;
                out_o.st_we = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/alu4_core.sv
`timescale 1ns/1ps
module alu4_core
    import alu4_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NIB_W-1:0] op_i,
    input  logic [NIB_W-1:0] a_i,
    input  logic [NIB_W-1:0] y_i,
    input  logic [NIB_W-1:0] m_i,
    input  logic [NIB_W-1:0] imm_i,
    input  logic             c_i,
    output logic [NIB_W-1:0] res_o,
    output logic             a_we_o,
    output logic             z_o,
    output logic             z_we_o,
    output logic             c_o,
    output logic             c_we_o,
    output logic             st_o,
    output logic             st_we_o
);
    alu_op_e  op_d;
    alu_out_t arith_d, logic_d, nxt_d, out_q;
    logic     use_logic_d;

    assign op_d = alu_op_e'(op_i);

    alu4_arith u_arith (
        .op_i  (op_d),
        .a_i   (a_i),
        .y_i   (y_i),
        .m_i   (m_i),
        .imm_i (imm_i),
        .c_i   (c_i),
        .out_o (arith_d)
    );

    alu4_logic u_logic (
        .op_i  (op_d),
        .a_i   (a_i),
        .m_i   (m_i),
        .c_i   (c_i),
        .out_o (logic_d)
    );

    always_comb begin
        unique case (op_d)
            OP_ROL, OP_ROR, OP_AND, OP_OR, OP_XOR: use_logic_d = 1'b1;
            default:                               use_logic_d = 1'b0;
        endcase
        nxt_d = use_logic_d ? logic_d : arith_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= nxt_d;
    end

    assign res_o   = out_q.res;
    assign a_we_o  = out_q.a_we;
    assign z_o     = out_q.z;
    assign z_we_o  = out_q.z_we;
    assign c_o     = out_q.c;
    assign c_we_o  = out_q.c_we;
    assign st_o    = out_q.st;
    assign st_we_o = out_q.st_we;
endmodule

// File: rtl/alu4_core_chk.sv
`timescale 1ns/1ps
module alu4_core_chk
    import alu4_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [NIB_W-1:0] op_i,
    input logic [NIB_W-1:0] a_i,
    input logic [NIB_W-1:0] m_i,
    input logic             c_i,
    input logic [NIB_W-1:0] res_o,
    input logic             a_we_o,
    input logic             z_o,
    input logic             z_we_o,
    input logic             c_o,
    input logic             c_we_o,
    input logic             st_o,
    input logic             st_we_o
);
    logic live_q;

    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!a_we_o && !z_we_o && !c_we_o && !st_we_o && res_o == '0));

    // R2
    adc_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && op_i == OP_ADC) |=>
        ({c_o, res_o} == ($past({1'b0, m_i}) + $past({1'b0, a_i}) + {4'd0, $past(c_i)})));

    // R5
    adjust_keeps_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && (op_i == OP_DAA || op_i == OP_DAS)) |=>
        (!z_we_o && c_we_o && st_o == !c_o));

    // R9
    logic_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR || op_i == OP_NEG)) |=>
        !c_we_o);

    // R11
    cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && (op_i == OP_CMPM || op_i == OP_CMPI || op_i == OP_CMPY)) |=>
        (!a_we_o && z_we_o && (z_o != st_o)));

    // R12
    reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && (op_i == OP_RSV0 || op_i == OP_RSV1)) |=>
        (!a_we_o && !z_we_o && !c_we_o && !st_we_o));

    // R13
    zero_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_we_o && z_we_o) |-> (z_o == (res_o == '0)));
endmodule

bind alu4_core alu4_core_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (op_i),
    .a_i     (a_i),
    .m_i     (m_i),
    .c_i     (c_i),
    .res_o   (res_o),
    .a_we_o  (a_we_o),
    .z_o     (z_o),
    .z_we_o  (z_we_o),
    .c_o     (c_o),
    .c_we_o  (c_we_o),
    .st_o    (st_o),
    .st_we_o (st_we_o)
);

// File: tb/alu4_core_tb_top.sv
`timescale 1ns/1ps
module alu4_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_i = '0, a_i = '0, y_i = '0, m_i = '0, imm_i = '0;
    logic       c_i = 1'b0;
    logic [3:0] res_o;
    logic       a_we_o, z_o, z_we_o, c_o, c_we_o, st_o, st_we_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    alu4_core dut_i (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .y_i(y_i),
        .m_i(m_i), .imm_i(imm_i), .c_i(c_i), .res_o(res_o),
        .a_we_o(a_we_o), .z_o(z_o), .z_we_o(z_we_o), .c_o(c_o),
        .c_we_o(c_we_o), .st_o(st_o), .st_we_o(st_we_o)
    );

    // packed expectation: {res[3:0], a_we, z, z_we, c, c_we, st, st_we}
    function automatic logic [10:0] model(int op, int a, int y, int m, int imm, int c);
        int r;
        int lo;
        logic [10:0] e;
        e = '0;
        case (op)
            0, 1, 2: begin  // R2 R3 R4
                r  = (op == 0) ? (m + a + c) : (op == 1) ? ((m - a - c) & 31) : (imm + a);
                lo = r & 15;
                e  = {4'(lo), 1'b1, 1'(lo == 0), 1'b1, 1'(r >> 4), 1'b1, 1'(!(r >> 4)), 1'b1};
            end
            3, 4: begin     // R5
                r  = (c != 0 || a > 9) ? (a + ((op == 3) ? 6 : 10)) : a;
                lo = r & 15;
                e  = {4'(lo), 1'b1, 1'b0, 1'b0, 1'(r >> 4), 1'b1, 1'(!(r >> 4)), 1'b1};
            end
            5: begin        // R6
                lo = ((a << 1) | c) & 15;
                e  = {4'(lo), 1'b1, 1'(lo == 0), 1'b1, 1'(a >> 3), 1'b1, 1'(!(a >> 3)), 1'b1};
            end
            6: begin        // R7
                lo = (a >> 1) | (c << 3);
                e  = {4'(lo), 1'b1, 1'(lo == 0), 1'b1, 1'(a & 1), 1'b1, 1'(!(a & 1)), 1'b1};
            end
            7: begin        // R8
                lo = (16 - a) & 15;
                e  = {4'(lo), 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'(lo != 0), 1'b1};
            end
            8, 9, 10: begin // R9 R10
                lo = (op == 8) ? (a & m) : (op == 9) ? (a | m) : (a ^ m);
                e  = {4'(lo), 1'b1, 1'(lo == 0), 1'b1, 1'b0, 1'b0, 1'(lo != 0), 1'b1};
            end
            11, 12, 13: begin // R11
                r  = (op == 11) ? ((m - a) & 31) : (op == 12) ? ((imm - a) & 31) : ((imm - y) & 31);
                lo = r & 15;
                e  = {4'd0, 1'b0, 1'(lo == 0), 1'b1, 1'(r >> 4), 1'b1, 1'(lo != 0), 1'b1};
            end
            default: e = '0; // R12
        endcase
        return e;
    endfunction

    function automatic string req_of(int op);
        case (op)
            0: return "R2";  1: return "R3";  2: return "R4";
            3, 4: return "R5"; 5: return "R6"; 6: return "R7"; 7: return "R8";
            8, 9: return "R9"; 10: return "R10";
            11, 12, 13: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic check(string req, logic [10:0] exp_v);
        logic [10:0] act;
        act = {res_o, a_we_o, z_o, z_we_o, c_o, c_we_o, st_o, st_we_o};
        n_run++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%0d m=%0d c=%0d actual=%b expected=%b",
                     req, op_i, a_i, m_i, c_i, act, exp_v);
        end
    endtask

    initial begin
        logic [10:0] e;
        // R1: reset state with an active operation applied
        op_i = 4'd0; a_i = 4'd9; m_i = 4'd9; c_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", 11'd0);
        rst_n = 1'b1;
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 16; a++) begin
                for (int m = 0; m < 16; m++) begin
                    for (int c = 0; c < 2; c++) begin
                        @(negedge clk);
                        op_i  = 4'(op);
                        a_i   = 4'(a);
                        m_i   = 4'(m);
                        c_i   = 1'(c);
                        imm_i = 4'((m * 5 + 1) & 15);
                        y_i   = 4'((m + a * 3) & 15);
                        e = model(op, a, int'(y_i), m, int'(imm_i), c);
                        // R1: result due one rising edge later
                        @(negedge clk);
                        check(req_of(op), e);
                        // R13 is covered by the Z field wherever A and Z are written
                    end
                end
            end
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule